// File: doc/BRIEF.md
# Logarithmic Companding Quantizer Pair

This block holds two independent streaming paths. The first path is a compressor. It takes a signed 12-bit linear sample and returns an 8-bit companded code. The magnitude is bent through the logarithmic curve ln(1+255·m)/ln(256), with m normalised so that full scale is one. The result is then quantized on a uniform grid of 2/256 over the range −1 to +1. The second path is an expander. It takes such a code and returns a signed 12-bit linear sample, applying the inverse curve ((256^|y|)−1)/255.

No floating point is used. The magnitude curve on each side is a chain of straight chords between exact points of the law, and these points are held in small constant tables. On the compressor side the breakpoints sit at successive powers of two of the input magnitude. On the expander side they sit every 16 code steps. The sign is split off before the curve and put back after it, so both transfers are odd-symmetric.

Each path runs through two register stages with a valid/ready handshake on each side. A stalled output holds its value and stops the path from taking new input.

Top module: `mu_companding_pair`

## Requirements
- R1: While reset is asserted and just after it is released, `code_valid_o` and `rec_valid_o` are low, and `lin_ready_o` and `cin_ready_o` are high.
- R2: Code encoding. The companded magnitude q lies on 0..128, in steps of 1/128 of full scale. A positive input gives code 128+q, clipped to 255. A negative input gives code 128−q. Input 0 gives 128, +2047 gives 255, and both −2047 and −2048 give 0, because the most negative input saturates to magnitude 2047.
- R3: The compressor's q is never more than 4 below, nor more than 1 above, round(128·ln(1+255·|v|/2047)/ln 256). On the positive side this ideal value is capped at 127.
- R4: Over the input range −2048..2047 the compressor code never decreases as the input increases.
- R5: For every v in 1..2047, code(v)+code(−v) equals 256. The only exception is code(v)=255, where code(−v) is 0.
- R6: Every nonzero input gives a code other than 128, so inputs of one LSB still stay distinct from zero.
- R7: For code c, let q=c−128. The expander output has the sign of q and lies within ideal/12+2 of ideal = (256^(|q|/128)−1)/255·2047. Code 128 gives 0 and code 0 gives −2047.
- R8: The expander output never decreases as the code increases, and out(c) = −out(256−c) for c in 1..255.
- R9: A round trip through compressor then expander returns a value within |v|/5+4 of v, with the same sign (or zero).
- R10: A sample accepted in cycle n appears at the output in cycle n+2 when the output is free. While an output is valid and not ready, it stays valid and unchanged, and the path stops accepting input once both stages are full.
- R11: With the output always ready, each path accepts a sample every cycle and delivers results on consecutive cycles in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lin_valid_i | input | 1 | Linear sample offered to the compressor |
| lin_ready_o | output | 1 | Compressor accepts the sample this cycle |
| lin_data_i | input | 12 | Signed linear sample |
| code_valid_o | output | 1 | Companded code available |
| code_ready_i | input | 1 | Downstream takes the code |
| code_o | output | 8 | Companded code, offset binary, 128 is zero |
| cin_valid_i | input | 1 | Code offered to the expander |
| cin_ready_o | output | 1 | Expander accepts the code this cycle |
| code_i | input | 8 | Companded code to expand |
| rec_valid_o | output | 1 | Reconstructed sample available |
| rec_ready_i | input | 1 | Downstream takes the sample |
| rec_data_o | output | 12 | Signed reconstructed linear sample |

## Verification
Each result is due two cycles after its input is accepted. Inputs are driven on the falling edge, so a handshake in cycle n is sampled on the falling edge of cycle n+2. That same falling edge is where the bench reads the output, and it checks that the output is still low one cycle earlier. The stall scenario holds ready low and checks the held value and the low input ready on every cycle. It then releases ready and expects the two queued results on back-to-back cycles. The full sweeps send one sample at a time into an empty pipe, so each result is read at the exact due cycle.

// File: rtl/mu_law_pkg.sv
package mu_law_pkg;
  localparam int LIN_W    = 12;
  localparam int CODE_W   = 8;
  localparam int MAG_W    = LIN_W - 1;
  localparam int MAG_MAX  = (1 << MAG_W) - 1;
  // compressor: first chord spans 2^KNEE_LOG, then one chord per octave
  localparam int KNEE_LOG = 4;
  localparam int CSEG_N   = MAG_W - KNEE_LOG + 1;
  localparam int CSEG_W   = $clog2(CSEG_N);
  localparam int COFF_W   = MAG_W - 1;
  localparam int KNOT_W   = 16;
  localparam int FRAC_C   = 8;
  localparam int QMAX     = 1 << (CODE_W - 1);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  // expander: uniform chords of 2^EOFF_W codes
  localparam int EOFF_W   = 4;
  localparam int ESEG_N   = QMAX >> EOFF_W;
  localparam int ESEG_W   = $clog2(ESEG_N + 1);
  localparam int FRAC_E   = 4;

  typedef struct packed {
    logic              neg;
    logic [CSEG_W-1:0] seg;
    logic [COFF_W-1:0] off;
  } cmp_s1_t;

  typedef struct packed {
    logic              neg;
    logic [ESEG_W-1:0] seg;
    logic [EOFF_W-1:0] off;
  } exp_s1_t;

  // 128*ln(1+255*m/2047)/ln256 in Q8 at m = 0,16,32,...,1024,2048
  function automatic logic [KNOT_W-1:0] cmp_knot(input int k);
    case (k)
      0:       cmp_knot = 16'd0;
      1:       cmp_knot = 16'd6479;
      2:       cmp_knot = 16'd9495;
      3:       cmp_knot = 16'd12966;
      4:       cmp_knot = 16'd16723;
      5:       cmp_knot = 16'd20642;
      6:       cmp_knot = 16'd24648;
      7:       cmp_knot = 16'd28698;
      default: cmp_knot = 16'd32771;
    endcase
  endfunction

  // (2^(q/16)-1)*2047/255 in Q4 at q = 0,16,...,128
  function automatic logic [KNOT_W-1:0] exp_knot(input int k);
    case (k)
      0:       exp_knot = 16'd0;
      1:       exp_knot = 16'd128;
      2:       exp_knot = 16'd385;
      3:       exp_knot = 16'd899;
      4:       exp_knot = 16'd1927;
      5:       exp_knot = 16'd3982;
      6:       exp_knot = 16'd8092;
      7:       exp_knot = 16'd16312;
      default: exp_knot = 16'd32752;
    endcase
  endfunction
endpackage

// File: rtl/mu_pipe_ctl.sv
module mu_pipe_ctl #(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [STAGES-1:0] load_o
);
  logic [STAGES-1:0] vld_q, adv, up_v;

  always_comb begin
    up_v = {vld_q[STAGES-2:0], in_valid_i};
    adv[STAGES-1] = ~vld_q[STAGES-1] | out_ready_i;
    for (int i = STAGES - 2; i >= 0; i--) adv[i] = ~vld_q[i] | adv[i+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else begin
      for (int i = 0; i < STAGES; i++)
        if (adv[i]) vld_q[i] <= up_v[i];
    end
  end

  assign load_o      = adv & up_v;
  assign in_ready_o  = adv[0];
  assign out_valid_o = vld_q[STAGES-1];
endmodule

// File: rtl/mu_compress.sv
module mu_compress
  import mu_law_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [LIN_W-1:0]  data_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int PROD_W = KNOT_W + COFF_W;
  localparam logic [LIN_W-1:0] MOST_NEG = {1'b1, {(LIN_W-1){1'b0}}};

  logic [1:0] load;

  mu_pipe_ctl #(.STAGES(2)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (valid_i),
    .in_ready_o  (ready_o),
    .out_ready_i (ready_i),
    .out_valid_o (valid_o),
    .load_o      (load)
  );

  // stage 1: sign split, saturation, octave search
  cmp_s1_t           s1_d, s1_q;
  logic [MAG_W-1:0]  mag_c, start_c;
  int                top_c;

  always_comb begin
    if (data_i == MOST_NEG) mag_c = MAG_W'(MAG_MAX);
    else if (data_i[LIN_W-1]) mag_c = MAG_W'(~data_i + 1'b1);
    else mag_c = data_i[MAG_W-1:0];
    top_c = -1;
    for (int b = 0; b < MAG_W; b++) if (mag_c[b]) top_c = b;
    s1_d.neg = data_i[LIN_W-1];
    if (top_c < KNEE_LOG) s1_d.seg = '0;
    else s1_d.seg = CSEG_W'(top_c - KNEE_LOG + 1);
    if (s1_d.seg == '0) start_c = '0;
    else start_c = MAG_W'(1) << (int'(s1_d.seg) + KNEE_LOG - 1);
    s1_d.off = COFF_W'(mag_c - start_c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else if (load[0]) s1_q <= s1_d;
  end

  // stage 2: chord interpolation and code assembly
  logic [KNOT_W-1:0] lo_c, hi_c, qfix_c;
  logic [PROD_W-1:0] prod_c, scaled_c;
  logic [KNOT_W:0]   rnd_c;
  logic [CODE_W-1:0] q_c, code_d, code_q;
  int                sh_c;

  always_comb begin
    lo_c     = cmp_knot(int'(s1_q.seg));
    hi_c     = cmp_knot(int'(s1_q.seg) + 1);
    sh_c     = (s1_q.seg == '0) ? KNEE_LOG : int'(s1_q.seg) + KNEE_LOG - 1;
    prod_c   = {{COFF_W{1'b0}}, hi_c - lo_c} * {{KNOT_W{1'b0}}, s1_q.off};
    scaled_c = prod_c >> sh_c;
    qfix_c   = lo_c + scaled_c[KNOT_W-1:0];
    rnd_c    = {1'b0, qfix_c} + (KNOT_W+1)'(1 << (FRAC_C - 1));
    q_c      = rnd_c[FRAC_C +: CODE_W];
    if (s1_q.neg) code_d = CODE_W'(QMAX) - q_c;
    else if (q_c >= CODE_W'(QMAX)) code_d = CODE_W'(CODE_MAX);
    else code_d = CODE_W'(QMAX) + q_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_W'(QMAX);
    else if (load[1]) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/mu_expand.sv
module mu_expand
  import mu_law_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [LIN_W-1:0]  data_o
);
  localparam int PROD_W = KNOT_W + EOFF_W;

  logic [1:0] load;

  mu_pipe_ctl #(.STAGES(2)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (valid_i),
    .in_ready_o  (ready_o),
    .out_ready_i (ready_i),
    .out_valid_o (valid_o),
    .load_o      (load)
  );

  // stage 1: offset-binary to sign/magnitude, chord select
  exp_s1_t           s1_d, s1_q;
  logic [CODE_W-1:0] mag_c;

  always_comb begin
    s1_d.neg = (code_i < CODE_W'(QMAX));
    mag_c    = s1_d.neg ? CODE_W'(QMAX) - code_i : code_i - CODE_W'(QMAX);
    s1_d.seg = mag_c[CODE_W-1:EOFF_W];
    s1_d.off = mag_c[EOFF_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else if (load[0]) s1_q <= s1_d;
  end

  // stage 2: chord interpolation, rounding, sign restore
  logic [KNOT_W-1:0] lo_c, hi_c, val_c;
  logic [PROD_W-1:0] prod_c, scaled_c;
  logic [KNOT_W:0]   rnd_c;
  logic [LIN_W-1:0]  mag_out_c, data_d, data_q;

  always_comb begin
    lo_c     = exp_knot(int'(s1_q.seg));
    hi_c     = (int'(s1_q.seg) == ESEG_N) ? lo_c : exp_knot(int'(s1_q.seg) + 1);
    prod_c   = {{EOFF_W{1'b0}}, hi_c - lo_c} * {{KNOT_W{1'b0}}, s1_q.off};
    scaled_c = prod_c >> EOFF_W;
    val_c    = lo_c + scaled_c[KNOT_W-1:0];
    rnd_c    = {1'b0, val_c} + (KNOT_W+1)'(1 << (FRAC_E - 1));
    mag_out_c = {1'b0, rnd_c[FRAC_E +: MAG_W]};
    if (mag_out_c > LIN_W'(MAG_MAX)) mag_out_c = LIN_W'(MAG_MAX);
    data_d   = s1_q.neg ? ~mag_out_c + 1'b1 : mag_out_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (load[1]) data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/mu_companding_pair.sv
module mu_companding_pair
  import mu_law_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lin_valid_i,
  output logic              lin_ready_o,
  input  logic [LIN_W-1:0]  lin_data_i,
  output logic              code_valid_o,
  input  logic              code_ready_i,
  output logic [CODE_W-1:0] code_o,
  input  logic              cin_valid_i,
  output logic              cin_ready_o,
  input  logic [CODE_W-1:0] code_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [LIN_W-1:0]  rec_data_o
);
  mu_compress u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (lin_valid_i),
    .ready_o (lin_ready_o),
    .data_i  (lin_data_i),
    .valid_o (code_valid_o),
    .ready_i (code_ready_i),
    .code_o  (code_o)
  );

  mu_expand u_exp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cin_valid_i),
    .ready_o (cin_ready_o),
    .code_i  (code_i),
    .valid_o (rec_valid_o),
    .ready_i (rec_ready_i),
    .data_o  (rec_data_o)
  );
endmodule

// File: rtl/mu_companding_chk.sv
module mu_companding_chk
  import mu_law_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lin_valid_i,
  input logic              lin_ready_o,
  input logic              code_valid_o,
  input logic              code_ready_i,
  input logic [CODE_W-1:0] code_o,
  input logic              cin_valid_i,
  input logic              cin_ready_o,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [LIN_W-1:0]  rec_data_o
);
  always @(posedge clk_i)
    if (!rst_ni) assert_reset_idle_R1: assert (!code_valid_o && !rec_valid_o);

  assert_hold_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o && !code_ready_i |=> code_valid_o && $stable(code_o));

  assert_hold_rec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_data_o));

  assert_code_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(code_valid_o) |-> $past(lin_valid_i && lin_ready_o, 2));

  assert_rec_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rec_valid_o) |-> $past(cin_valid_i && cin_ready_o, 2));
endmodule

bind mu_companding_pair mu_companding_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lin_valid_i  (lin_valid_i),
  .lin_ready_o  (lin_ready_o),
  .code_valid_o (code_valid_o),
  .code_ready_i (code_ready_i),
  .code_o       (code_o),
  .cin_valid_i  (cin_valid_i),
  .cin_ready_o  (cin_ready_o),
  .rec_valid_o  (rec_valid_o),
  .rec_ready_i  (rec_ready_i),
  .rec_data_o   (rec_data_o)
);

// File: tb/mu_companding_pair_test.sv
module mu_companding_pair_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lin_valid = 1'b0, code_ready = 1'b1, cin_valid = 1'b0, rec_ready = 1'b1;
  logic [11:0] lin_data = '0;
  logic [7:0]  cin_code = 8'd128;
  logic lin_ready, code_valid, cin_ready, rec_valid;
  logic [7:0]  code_out;
  logic [11:0] rec_out;

  always #10 clk = ~clk;

  mu_companding_pair uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lin_valid_i(lin_valid), .lin_ready_o(lin_ready), .lin_data_i(lin_data),
    .code_valid_o(code_valid), .code_ready_i(code_ready), .code_o(code_out),
    .cin_valid_i(cin_valid), .cin_ready_o(cin_ready), .code_i(cin_code),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready), .rec_data_o(rec_out)
  );

  int n_chk = 0, n_err = 0;
  int c_tab[4096];
  int r_tab[256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ideal_q(input int v);
    real m, y;
    m = (v < 0) ? -v : v;
    if (m > 2047.0) m = 2047.0;
    y = 128.0 * $ln(1.0 + 255.0 * m / 2047.0) / $ln(256.0);
    return $rtoi(y + 0.5);
  endfunction

  function automatic real ideal_rec(input int c);
    int q;
    real m;
    q = c - 128;
    m = ($pow(256.0, ((q < 0) ? -q : q) / 128.0) - 1.0) / 255.0 * 2047.0;
    return (q < 0) ? -m : m;
  endfunction

  function automatic int s12(input logic [11:0] x);
    return int'($signed(x));
  endfunction

  // one sample into an empty compressor, read in cycle n+2
  task automatic comp_one(input int v, output int code, input bit lat_chk);
    @(negedge clk); lin_valid = 1'b1; lin_data = 12'(v);
    @(posedge clk);
    @(negedge clk); lin_valid = 1'b0;
    if (lat_chk) check(!code_valid, "R10 comp early", int'(code_valid), 0);
    @(negedge clk);
    if (lat_chk) check(code_valid, "R10 comp due", int'(code_valid), 1);
    code = code_valid ? int'(code_out) : -1;
  endtask

  task automatic exp_one(input int c, output int r, input bit lat_chk);
    @(negedge clk); cin_valid = 1'b1; cin_code = 8'(c);
    @(posedge clk);
    @(negedge clk); cin_valid = 1'b0;
    if (lat_chk) check(!rec_valid, "R10 exp early", int'(rec_valid), 0);
    @(negedge clk);
    if (lat_chk) check(rec_valid, "R10 exp due", int'(rec_valid), 1);
    r = rec_valid ? s12(rec_out) : 99999;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!code_valid && !rec_valid, "R1 valids low in reset", int'(code_valid | rec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!code_valid && !rec_valid, "R1 valids low after reset", int'(code_valid | rec_valid), 0);
    check(lin_ready && cin_ready, "R1 readies high", int'(lin_ready & cin_ready), 1);
  endtask

  task automatic t_endpoints();
    int c;
    comp_one(0, c, 1'b0);     check(c == 128, "R2 zero", c, 128);
    comp_one(2047, c, 1'b0);  check(c == 255, "R2 +full", c, 255);
    comp_one(-2047, c, 1'b0); check(c == 0, "R2 -full", c, 0);
    comp_one(-2048, c, 1'b0); check(c == 0, "R2 most negative", c, 0);
  endtask

  task automatic t_comp_sweep();
    for (int v = -2048; v < 2048; v++) begin
      int c, qa, qi;
      comp_one(v, c, 1'b0);
      c_tab[v + 2048] = c;
      qi = ideal_q(v);
      if (v >= 0) begin
        qa = c - 128;
        if (qi > 127) qi = 127;
      end else qa = 128 - c;
      check(qa >= qi - 4 && qa <= qi + 1, "R3 curve accuracy", qa, qi);
    end
  endtask

  task automatic t_comp_shape();
    for (int i = 1; i < 4096; i++)
      check(c_tab[i] >= c_tab[i-1], "R4 monotonic", c_tab[i], c_tab[i-1]);
    for (int v = 1; v < 2048; v++) begin
      int p, n;
      p = c_tab[v + 2048];
      n = c_tab[2048 - v];
      check((p + n == 256) || (p == 255 && n == 0), "R5 odd symmetry", p + n, 256);
      check(p != 128 && n != 128, "R6 nonzero input off zero code", (p == 128) ? p : n, 129);
    end
  endtask

  task automatic t_exp_sweep();
    int r;
    for (int c = 0; c < 256; c++) begin
      real id, err;
      exp_one(c, r, c == 77);
      r_tab[c] = r;
      id = ideal_rec(c);
      err = r - id;
      if (err < 0.0) err = -err;
      check(err <= ((id < 0.0) ? -id : id) / 12.0 + 2.0, "R7 inverse accuracy", r, $rtoi(id));
    end
    check(r_tab[128] == 0, "R7 code 128", r_tab[128], 0);
    check(r_tab[0] == -2047, "R7 code 0", r_tab[0], -2047);
    for (int c = 1; c < 256; c++) begin
      check(r_tab[c] >= r_tab[c-1], "R8 monotonic", r_tab[c], r_tab[c-1]);
      check(r_tab[c] == -r_tab[256 - c], "R8 symmetry", r_tab[c], -r_tab[256 - c]);
    end
  endtask

  task automatic t_round_trip();
    int vals[6] = '{1, -3, 7, 100, -768, 2000};
    for (int v = -2048; v < 2048; v++) begin
      int rt, av, d;
      rt = r_tab[c_tab[v + 2048]];
      av = (v < 0) ? -v : v;
      d  = rt - v;
      if (d < 0) d = -d;
      check(d * 5 <= av + 20 && !(v > 0 && rt < 0) && !(v < 0 && rt > 0),
            "R9 round trip", rt, v);
    end
    foreach (vals[i]) begin
      int c, r, av, d;
      comp_one(vals[i], c, 1'b1);
      exp_one(c, r, 1'b1);
      av = (vals[i] < 0) ? -vals[i] : vals[i];
      d = r - vals[i];
      if (d < 0) d = -d;
      check(d * 5 <= av + 20, "R9 live round trip", r, vals[i]);
    end
  endtask

  task automatic t_stall();
    int a = 300, b = -50, c = 9;
    code_ready = 1'b0;
    @(negedge clk); lin_valid = 1'b1; lin_data = 12'(a);
    check(lin_ready, "R10 accept first", int'(lin_ready), 1);
    @(negedge clk); lin_data = 12'(b);
    check(lin_ready, "R10 accept second", int'(lin_ready), 1);
    @(negedge clk); lin_data = 12'(c);
    for (int k = 0; k < 3; k++) begin
      check(!lin_ready, "R10 full pipe stalls input", int'(lin_ready), 0);
      check(code_valid && int'(code_out) == c_tab[a + 2048], "R10 held output",
            int'(code_out), c_tab[a + 2048]);
      @(negedge clk);
    end
    lin_valid = 1'b0; code_ready = 1'b1;
    check(code_valid && int'(code_out) == c_tab[a + 2048], "R10 first after stall",
          int'(code_out), c_tab[a + 2048]);
    @(negedge clk);
    check(code_valid && int'(code_out) == c_tab[b + 2048], "R10 second after stall",
          int'(code_out), c_tab[b + 2048]);
    @(negedge clk);
    check(!code_valid, "R10 unaccepted sample dropped", int'(code_valid), 0);
  endtask

  task automatic t_stream();
    int v[4] = '{-2048, -5, 64, 1500};
    int cs[4] = '{0, 255, 128, 1};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i < 4) begin
        lin_valid = 1'b1; lin_data = 12'(v[i]);
        cin_valid = 1'b1; cin_code = 8'(cs[i]);
        check(lin_ready && cin_ready, "R11 ready every cycle", int'(lin_ready & cin_ready), 1);
      end else begin
        lin_valid = 1'b0; cin_valid = 1'b0;
      end
      if (i >= 2) begin
        check(code_valid && int'(code_out) == c_tab[v[i-2] + 2048], "R11 code in order",
              int'(code_out), c_tab[v[i-2] + 2048]);
        check(rec_valid && s12(rec_out) == r_tab[cs[i-2]], "R11 sample in order",
              s12(rec_out), r_tab[cs[i-2]]);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_endpoints();
    t_comp_sweep();
    t_comp_shape();
    t_exp_sweep();
    t_round_trip();
    t_stall();
    t_stream();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule